// File: doc/BRIEF.md
# Programmable Bit-Serial CRC Engine

This block computes a cyclic redundancy check one bit per clock over a stream of data words. Both the word width (1 to 32 bits) and the polynomial length (1 to 32 bits) are set at run time, each through a 5-bit field that holds the value minus one. The polynomial is supplied as a tap mask, and a seed value preloads the shift register. Software writes words into a small input FIFO. After the start control rises, the engine pulls words from the FIFO and feeds their bits through a linear feedback register. A word can enter least significant bit first or most significant bit first.

A one-cycle interrupt pulse marks completion at one of two points. In the early mode it fires when the FIFO drains, while the last word is still being shifted. In the late mode it fires when the last bit has been absorbed and the result is final. Dropping the start control aborts shifting. Dropping the enable clears the FIFO, the shift register and all sequencing state, while the configuration inputs keep their values. A freeze option lets an external idle input pause shifting.

Top module: `crc_serial_engine`

## Requirements
- R1: `cfg_dw_m1` holds the word width minus one. Only bits `cfg_dw_m1` down to 0 of each queued word enter the CRC, and higher bits have no effect on the result.
- R2: `cfg_plen_m1` (written P below) holds the polynomial length minus one. The feedback bit is register bit P, and `result` only has bits P..0 set.
- R3: For each input bit b, with f = crc[P] ^ b, the register becomes ((crc << 1) ^ (f ? cfg_taps : 0)) masked to bits P..0. For example, P = 15, taps 0x1021, seed 0xFFFF, MSb-first bytes "123456789" give 0x29B1.
- R4: With `cfg_lsb_first` = 1, a word's bits enter from bit 0 upward. With 0, they enter from bit `cfg_dw_m1` downward.
- R5: A rising edge of `cfg_go` while enabled loads the seed, masked to P..0, into the register. After that exactly one bit is shifted per clock, with no gap between words already queued.
- R6: Driving `cfg_go` low stops shifting. `busy` is low on the next cycle and `result` holds its value. Words still queued stay in the FIFO.
- R7: While `cfg_en` is low, the next cycle shows an empty FIFO (level 0), `busy` low, `result` 0 and `irq` low.
- R8: While `cfg_freeze_idle` and `idle_in` are both high, no bit is shifted and no word is fetched. `result` and `busy` hold, and shifting resumes unchanged afterwards.
- R9: With `cfg_irq_on_empty` = 1, `irq` pulses for one cycle in the cycle the FIFO becomes empty through a fetch. At that point `busy` is still high.
- R10: With `cfg_irq_on_empty` = 0, `irq` pulses for one cycle in the cycle the last bit has been absorbed with no further word queued. At that point `busy` is low and `result` is final.
- R11: The FIFO holds FIFO_DEPTH words. `fifo_level`, `fifo_full` and `fifo_empty` report its state. Writes are ignored while it is full or while `cfg_en` is low.
- R12: `busy` is high from the cycle after the first fetch until the last bit of the final queued word has been consumed. It rises only after a fetch from a non-empty FIFO.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cfg_en | input | 1 | Engine enable; low clears FIFO and state |
| cfg_go | input | 1 | Start on rising edge, abort when low |
| cfg_lsb_first | input | 1 | Bit order select |
| cfg_irq_on_empty | input | 1 | Interrupt point select |
| cfg_freeze_idle | input | 1 | Allow `idle_in` to pause shifting |
| idle_in | input | 1 | System idle indication |
| cfg_dw_m1 | input | 5 | Word width minus one |
| cfg_plen_m1 | input | 5 | Polynomial length minus one |
| cfg_taps | input | 32 | Polynomial tap mask |
| cfg_seed | input | 32 | Initial register value |
| wr_valid | input | 1 | Write a word into the FIFO |
| wr_data | input | 32 | Word to queue |
| fifo_full | output | 1 | FIFO full |
| fifo_empty | output | 1 | FIFO empty |
| fifo_level | output | 4 | Number of queued words |
| busy | output | 1 | Shifting in progress |
| result | output | 32 | CRC register value |
| irq | output | 1 | One-cycle completion pulse |

## Verification
The bench goes after bit order and the width/length boundaries: 1-bit words, 32-bit words and 1-bit polynomials. A design that picked the wrong bit, masked the wrong way or fed back from the wrong tap would give a different CRC from the bench model. It counts the busy cycles of every preloaded job. A design that inserted a bubble between words or skipped a bit would miss the count of words × width. It checks both interrupt points against `busy` and `fifo_empty`, so a pulse fired at the wrong point or fired twice is caught. It freezes, aborts and disables mid-job, and overfills the FIFO. A design that kept shifting while frozen, lost queued words on abort, kept state across disable or accepted a word while full would show a moved result or a wrong level.

// File: rtl/crc_eng_pkg.sv
package crc_eng_pkg;

   // sequencing state of the engine
   typedef enum logic [0:0] {
      ENG_IDLE = 1'b0,
      ENG_RUN  = 1'b1
   } eng_state_e;

   // widest word / polynomial the control fields can describe
   localparam int ENG_MAX_W = 32;

endpackage

// File: rtl/crc_word_fifo.sv
module crc_word_fifo #(
   parameter int W     = 32,
   parameter int DEPTH = 8,
   localparam int AW   = $clog2(DEPTH),
   localparam int LW   = $clog2(DEPTH + 1)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          clr,
   input  logic          push,
   input  logic [W-1:0]  din,
   input  logic          pop,
   output logic [W-1:0]  dout,
   output logic [LW-1:0] level,
   output logic          full,
   output logic          empty
);

   if ((DEPTH < 2) || ((1 << AW) != DEPTH)) begin : g_bad_depth
      $error("crc_word_fifo: DEPTH must be a power of two of at least 2");
   end

   logic [W-1:0]  mem [DEPTH];
   logic [AW-1:0] rd_ptr;
   logic [AW-1:0] wr_ptr;
   logic [LW-1:0] cnt;
   logic          push_ok;
   logic          pop_ok;

   assign full    = (cnt == LW'(DEPTH));
   assign empty   = (cnt == '0);
   assign push_ok = push & ~full;
   assign pop_ok  = pop & ~empty;
   assign dout    = mem[rd_ptr];
   assign level   = cnt;

   always_ff @(posedge clk) begin
      if (push_ok) begin
         mem[wr_ptr] <= din;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rd_ptr <= '0;
         wr_ptr <= '0;
         cnt    <= '0;
      end else if (clr) begin
         rd_ptr <= '0;
         wr_ptr <= '0;
         cnt    <= '0;
      end else begin
         if (push_ok) wr_ptr <= wr_ptr + AW'(1);
         if (pop_ok)  rd_ptr <= rd_ptr + AW'(1);
         case ({push_ok, pop_ok})
            2'b10:   cnt <= cnt + LW'(1);
            2'b01:   cnt <= cnt - LW'(1);
            default: cnt <= cnt;
         endcase
      end
   end

endmodule

// File: rtl/crc_lfsr_step.sv
module crc_lfsr_step #(
   parameter int W   = 32,
   localparam int FW = $clog2(W)
) (
   input  logic [W-1:0]  crc_in,
   input  logic          bit_in,
   input  logic [W-1:0]  taps,
   input  logic [FW-1:0] top,
   output logic [W-1:0]  crc_out
);

   logic fb;

   assign fb = crc_in[top] ^ bit_in;

   for (genvar i = 0; i < W; i++) begin : g_cell
      logic keep;
      assign keep = (FW'(i) <= top);
      if (i == 0) begin : g_lsb
         assign crc_out[i] = keep & (fb & taps[i]);
      end else begin : g_upper
         assign crc_out[i] = keep & (crc_in[i-1] ^ (fb & taps[i]));
      end
   end

endmodule

// File: rtl/crc_bit_pick.sv
module crc_bit_pick #(
   parameter int W   = 32,
   localparam int FW = $clog2(W)
) (
   input  logic [W-1:0]  word,
   input  logic [FW-1:0] idx,
   input  logic [FW-1:0] last_idx,
   input  logic          lsb_first,
   output logic          bit_out
);

   logic [FW-1:0] sel;

   assign sel     = lsb_first ? idx : (last_idx - idx);
   assign bit_out = word[sel];

endmodule

// File: rtl/crc_seq_ctrl.sv
module crc_seq_ctrl
   import crc_eng_pkg::*;
#(
   parameter int W   = 32,
   localparam int FW = $clog2(W)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          en,
   input  logic          go,
   input  logic          lsb_first,
   input  logic          irq_on_empty,
   input  logic          frozen,
   input  logic [FW-1:0] dw,
   input  logic [FW-1:0] plen,
   input  logic [W-1:0]  taps,
   input  logic [W-1:0]  seed,
   input  logic [W-1:0]  fifo_dout,
   input  logic          fifo_empty,
   input  logic          fifo_one,
   input  logic          push_ok,
   output logic          pop,
   output logic          busy,
   output logic [W-1:0]  result,
   output logic          irq
);

   eng_state_e    st;
   logic          have;
   logic          go_q;
   logic [FW-1:0] idx;
   logic [W-1:0]  word;
   logic [W-1:0]  crc;
   logic [W-1:0]  crc_nx;
   logic [W-1:0]  mask;
   logic          cur_bit;
   logic          start;
   logic          last;
   logic          shift_en;

   for (genvar i = 0; i < W; i++) begin : g_mask
      assign mask[i] = (FW'(i) <= plen);
   end

   crc_bit_pick #(.W(W)) u_pick (
      .word      (word),
      .idx       (idx),
      .last_idx  (dw),
      .lsb_first (lsb_first),
      .bit_out   (cur_bit)
   );

   crc_lfsr_step #(.W(W)) u_step (
      .crc_in  (crc),
      .bit_in  (cur_bit),
      .taps    (taps),
      .top     (plen),
      .crc_out (crc_nx)
   );

   assign start    = en & go & ~go_q;
   assign shift_en = en & go & ~start & (st == ENG_RUN) & ~frozen;
   assign last     = (idx == dw);
   assign pop      = shift_en & (~have | last) & ~fifo_empty;
   assign busy     = have;
   assign result   = crc;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st   <= ENG_IDLE;
         have <= 1'b0;
         go_q <= 1'b0;
         idx  <= '0;
         word <= '0;
         crc  <= '0;
         irq  <= 1'b0;
      end else if (!en) begin
         st   <= ENG_IDLE;
         have <= 1'b0;
         go_q <= 1'b0;
         idx  <= '0;
         word <= '0;
         crc  <= '0;
         irq  <= 1'b0;
      end else begin
         go_q <= go;
         irq  <= 1'b0;
         if (start) begin
            st   <= ENG_RUN;
            crc  <= seed & mask;
            have <= 1'b0;
            idx  <= '0;
         end else if (!go) begin
            st   <= ENG_IDLE;
            have <= 1'b0;
            idx  <= '0;
         end else if (shift_en) begin
            if (have) begin
               crc <= crc_nx;
            end
            if (pop) begin
               have <= 1'b1;
               word <= fifo_dout;
               idx  <= '0;
            end else if (have && last) begin
               have <= 1'b0;
            end else if (have) begin
               idx <= idx + FW'(1);
            end
            if (irq_on_empty && pop && fifo_one && !push_ok) begin
               irq <= 1'b1;
            end
            if (!irq_on_empty && have && last && !pop) begin
               irq <= 1'b1;
            end
         end
      end
   end

endmodule

// File: rtl/crc_serial_engine.sv
module crc_serial_engine
   import crc_eng_pkg::*;
#(
   parameter int DATA_W     = 32,
   parameter int FIFO_DEPTH = 8,
   localparam int FW        = $clog2(DATA_W),
   localparam int LW        = $clog2(FIFO_DEPTH + 1)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cfg_en,
   input  logic              cfg_go,
   input  logic              cfg_lsb_first,
   input  logic              cfg_irq_on_empty,
   input  logic              cfg_freeze_idle,
   input  logic              idle_in,
   input  logic [FW-1:0]     cfg_dw_m1,
   input  logic [FW-1:0]     cfg_plen_m1,
   input  logic [DATA_W-1:0] cfg_taps,
   input  logic [DATA_W-1:0] cfg_seed,
   input  logic              wr_valid,
   input  logic [DATA_W-1:0] wr_data,
   output logic              fifo_full,
   output logic              fifo_empty,
   output logic [LW-1:0]     fifo_level,
   output logic              busy,
   output logic [DATA_W-1:0] result,
   output logic              irq
);

   if ((DATA_W < 2) || (DATA_W > ENG_MAX_W) || ((1 << FW) != DATA_W)) begin : g_bad_width
      $error("crc_serial_engine: DATA_W must be a power of two between 2 and 32");
   end

   logic              push_ok;
   logic              pop;
   logic              frozen;
   logic              fifo_one;
   logic [DATA_W-1:0] head;

   assign push_ok  = wr_valid & cfg_en & ~fifo_full;
   assign frozen   = cfg_freeze_idle & idle_in;
   assign fifo_one = (fifo_level == LW'(1));

   crc_word_fifo #(.W(DATA_W), .DEPTH(FIFO_DEPTH)) u_fifo (
      .clk   (clk),
      .rst_n (rst_n),
      .clr   (~cfg_en),
      .push  (push_ok),
      .din   (wr_data),
      .pop   (pop),
      .dout  (head),
      .level (fifo_level),
      .full  (fifo_full),
      .empty (fifo_empty)
   );

   crc_seq_ctrl #(.W(DATA_W)) u_ctrl (
      .clk          (clk),
      .rst_n        (rst_n),
      .en           (cfg_en),
      .go           (cfg_go),
      .lsb_first    (cfg_lsb_first),
      .irq_on_empty (cfg_irq_on_empty),
      .frozen       (frozen),
      .dw           (cfg_dw_m1),
      .plen         (cfg_plen_m1),
      .taps         (cfg_taps),
      .seed         (cfg_seed),
      .fifo_dout    (head),
      .fifo_empty   (fifo_empty),
      .fifo_one     (fifo_one),
      .push_ok      (push_ok),
      .pop          (pop),
      .busy         (busy),
      .result       (result),
      .irq          (irq)
   );

endmodule

// File: rtl/crc_serial_engine_chk.sv
module crc_serial_engine_chk #(
   parameter int DATA_W     = 32,
   parameter int FIFO_DEPTH = 8,
   localparam int FW        = $clog2(DATA_W),
   localparam int LW        = $clog2(FIFO_DEPTH + 1)
) (
   input logic              clk,
   input logic              rst_n,
   input logic              cfg_en,
   input logic              cfg_go,
   input logic              cfg_irq_on_empty,
   input logic              cfg_freeze_idle,
   input logic              idle_in,
   input logic [FW-1:0]     cfg_plen_m1,
   input logic              fifo_full,
   input logic              fifo_empty,
   input logic [LW-1:0]     fifo_level,
   input logic              busy,
   input logic [DATA_W-1:0] result,
   input logic              irq
);

   function automatic logic [DATA_W-1:0] low_ones(input logic [FW-1:0] p);
      logic [DATA_W-1:0] m;
      for (int i = 0; i < DATA_W; i++) begin
         m[i] = (i <= int'(p));
      end
      return m;
   endfunction

   logic frz;
   assign frz = cfg_freeze_idle & idle_in;

   // R11
   fifo_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (fifo_level <= LW'(FIFO_DEPTH)) && (fifo_full == (fifo_level == LW'(FIFO_DEPTH)))
      && (fifo_empty == (fifo_level == '0)));

   // R7
   disable_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !cfg_en |=> (fifo_level == '0) && !busy && (result == '0) && !irq);

   // R6
   abort_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg_en && !cfg_go) |=> !busy);

   // R8
   freeze_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg_en && $past(cfg_en) && cfg_go && $past(cfg_go) && frz && busy)
      |=> ($stable(result) && busy));

   // R9
   early_irq_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (irq && cfg_irq_on_empty && $stable(cfg_irq_on_empty)) |-> (fifo_empty && busy));

   // R10
   late_irq_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (irq && !cfg_irq_on_empty && $stable(cfg_irq_on_empty)) |-> !busy);

   // R2
   result_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(busy) && $past(cfg_go) && cfg_go && !$past(frz) && $stable(cfg_plen_m1)
       && cfg_en && $past(cfg_en)) |-> ((result & ~low_ones(cfg_plen_m1)) == '0));

   // R12
   busy_needs_word_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(busy) |-> $past(!fifo_empty));

endmodule

bind crc_serial_engine crc_serial_engine_chk #(
   .DATA_W     (DATA_W),
   .FIFO_DEPTH (FIFO_DEPTH)
) u_chk (
   .clk              (clk),
   .rst_n            (rst_n),
   .cfg_en           (cfg_en),
   .cfg_go           (cfg_go),
   .cfg_irq_on_empty (cfg_irq_on_empty),
   .cfg_freeze_idle  (cfg_freeze_idle),
   .idle_in          (idle_in),
   .cfg_plen_m1      (cfg_plen_m1),
   .fifo_full        (fifo_full),
   .fifo_empty       (fifo_empty),
   .fifo_level       (fifo_level),
   .busy             (busy),
   .result           (result),
   .irq              (irq)
);

// File: tb/crc_serial_engine_bench.sv
module crc_serial_engine_bench;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        cfg_en = 1'b0;
   logic        cfg_go = 1'b0;
   logic        cfg_lsb_first = 1'b0;
   logic        cfg_irq_on_empty = 1'b0;
   logic        cfg_freeze_idle = 1'b0;
   logic        idle_in = 1'b0;
   logic [4:0]  cfg_dw_m1 = '0;
   logic [4:0]  cfg_plen_m1 = '0;
   logic [31:0] cfg_taps = '0;
   logic [31:0] cfg_seed = '0;
   logic        wr_valid = 1'b0;
   logic [31:0] wr_data = '0;
   logic        fifo_full;
   logic        fifo_empty;
   logic [3:0]  fifo_level;
   logic        busy;
   logic [31:0] result;
   logic        irq;

   int total = 0;
   int bad = 0;
   logic [31:0] jw [16];

   always #4 clk = ~clk;

   crc_serial_engine u_crc_serial_engine (
      .clk(clk), .rst_n(rst_n), .cfg_en(cfg_en), .cfg_go(cfg_go),
      .cfg_lsb_first(cfg_lsb_first), .cfg_irq_on_empty(cfg_irq_on_empty),
      .cfg_freeze_idle(cfg_freeze_idle), .idle_in(idle_in),
      .cfg_dw_m1(cfg_dw_m1), .cfg_plen_m1(cfg_plen_m1), .cfg_taps(cfg_taps),
      .cfg_seed(cfg_seed), .wr_valid(wr_valid), .wr_data(wr_data),
      .fifo_full(fifo_full), .fifo_empty(fifo_empty), .fifo_level(fifo_level),
      .busy(busy), .result(result), .irq(irq)
   );

   task automatic chk(input bit ok, input string what, input logic [31:0] act, input logic [31:0] exp);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s act=%h exp=%h", what, act, exp);
      end
   endtask

   function automatic logic [31:0] ref_crc(input int n);
      logic [31:0] m;
      logic [31:0] cur;
      int pl;
      int dw;
      pl = int'(cfg_plen_m1);
      dw = int'(cfg_dw_m1);
      for (int i = 0; i < 32; i++) m[i] = (i <= pl);
      cur = cfg_seed & m;
      for (int k = 0; k < n; k++) begin
         for (int b = 0; b <= dw; b++) begin
            logic bi;
            logic fb;
            bi  = cfg_lsb_first ? jw[k][b] : jw[k][dw - b];
            fb  = cur[pl] ^ bi;
            cur = ((cur << 1) ^ (fb ? cfg_taps : 32'd0)) & m;
         end
      end
      return cur;
   endfunction

   task automatic push_words(input int n);
      for (int k = 0; k < n; k++) begin
         @(negedge clk);
         wr_valid = 1'b1;
         wr_data  = jw[k];
      end
      @(negedge clk);
      wr_valid = 1'b0;
   endtask

   // runs a job over n preloaded words and checks result, irq point and bit rate
   task automatic run_job(input string tag, input int n, input bit count_bits);
      logic [31:0] exp;
      int bc;
      int irq_n;
      bit fin;
      exp = ref_crc(n);
      bc = 0; irq_n = 0; fin = 0;
      @(negedge clk);
      cfg_go = 1'b1;
      for (int k = 0; k < 4000; k++) begin
         @(negedge clk);
         if (busy) bc++;
         if (irq) begin
            irq_n++;
            if (cfg_irq_on_empty)
               chk(busy && fifo_empty, {"R9 early irq point ", tag}, {30'd0, busy, fifo_empty}, 32'd3);
            else
               chk(!busy, {"R10 late irq point ", tag}, {31'd0, busy}, 32'd0);
         end
         if (bc > 0 && !busy) begin
            fin = 1;
            break;
         end
      end
      chk(fin && irq_n == 1, {"R9 R10 R12 single irq and busy end ", tag}, irq_n, 32'd1);
      chk(result == exp, {"R1 R3 R4 crc value ", tag}, result, exp);
      if (count_bits)
         chk(bc == n * (int'(cfg_dw_m1) + 1), {"R5 R12 one bit per clock ", tag}, bc, n * (int'(cfg_dw_m1) + 1));
      @(negedge clk);
      cfg_go = 1'b0;
      @(negedge clk);
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      bad++;
      $display("FAIL watchdog expired act=%h exp=%h", 32'd1, 32'd0);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      logic [31:0] r0;
      int rs;
      bit okf;
      rs = $urandom(32'd2024);
      repeat (4) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // reset state
      chk(fifo_empty && !fifo_full && fifo_level == 0 && !busy && !irq && result == 0,
          "R7 R11 reset state", {fifo_level, 26'd0, busy, irq}, 32'd0);

      // R11: write while disabled is ignored
      jw[0] = 32'hDEAD_BEEF;
      push_words(1);
      chk(fifo_level == 0 && fifo_empty, "R11 write ignored while disabled", fifo_level, 32'd0);

      cfg_en = 1'b1;
      @(negedge clk);

      // R3: standard 16-bit vector
      cfg_dw_m1 = 5'd7; cfg_plen_m1 = 5'd15; cfg_taps = 32'h1021; cfg_seed = 32'hFFFF;
      cfg_lsb_first = 1'b0; cfg_irq_on_empty = 1'b0;
      for (int k = 0; k < 9; k++) jw[k] = 32'h31 + k;
      push_words(8);
      chk(fifo_full && fifo_level == 8, "R11 full after depth writes", fifo_level, 32'd8);
      cfg_go = 1'b1;
      for (int k = 0; k < 50 && fifo_full; k++) @(negedge clk);
      wr_valid = 1'b1; wr_data = jw[8];
      @(negedge clk);
      wr_valid = 1'b0;
      okf = 0;
      for (int k = 0; k < 2000; k++) begin
         @(negedge clk);
         if (irq) begin okf = 1; break; end
      end
      chk(okf && result == 32'h29B1, "R3 known vector", result, 32'h29B1);
      cfg_go = 1'b0;
      @(negedge clk);

      // R11: overfill, only first depth words count
      cfg_dw_m1 = 5'd7; cfg_plen_m1 = 5'd7; cfg_taps = 32'h07; cfg_seed = 32'h00;
      for (int k = 0; k < 11; k++) jw[k] = $urandom;
      push_words(11);
      chk(fifo_level == 8 && fifo_full, "R11 extra writes dropped", fifo_level, 32'd8);
      run_job("overfill", 8, 1'b1);

      // boundary widths
      cfg_dw_m1 = 5'd0; cfg_plen_m1 = 5'd0; cfg_taps = 32'h1; cfg_seed = 32'h1; cfg_lsb_first = 1'b1;
      for (int k = 0; k < 8; k++) jw[k] = $urandom;
      push_words(5);
      run_job("1-bit words 1-bit poly", 5, 1'b1);
      cfg_dw_m1 = 5'd31; cfg_plen_m1 = 5'd31; cfg_taps = 32'h04C1_1DB7; cfg_seed = 32'hFFFF_FFFF;
      cfg_lsb_first = 1'b0; cfg_irq_on_empty = 1'b1;
      push_words(3);
      run_job("32-bit words 32-bit poly", 3, 1'b1);

      // random configurations
      for (int j = 0; j < 24; j++) begin
         int n;
         cfg_dw_m1 = 5'($urandom % 32);
         cfg_plen_m1 = 5'($urandom % 32);
         cfg_taps = $urandom; cfg_seed = $urandom;
         cfg_lsb_first = 1'($urandom % 2);
         cfg_irq_on_empty = 1'($urandom % 2);
         n = 1 + ($urandom % 8);
         for (int k = 0; k < n; k++) jw[k] = $urandom;
         push_words(n);
         run_job($sformatf("random job %0d", j), n, 1'b1);
      end

      // R8: freeze mid-job
      cfg_dw_m1 = 5'd31; cfg_plen_m1 = 5'd31; cfg_taps = 32'h8000_0057; cfg_seed = 32'h1234_5678;
      cfg_lsb_first = 1'b1; cfg_irq_on_empty = 1'b0; cfg_freeze_idle = 1'b1;
      for (int k = 0; k < 4; k++) jw[k] = $urandom;
      push_words(4);
      fork
         run_job("after freeze", 4, 1'b0);
         begin
            repeat (21) @(negedge clk);
            idle_in = 1'b1;
            r0 = result;
            okf = 1;
            repeat (6) begin
               @(negedge clk);
               if (result != r0 || !busy) okf = 0;
            end
            chk(okf, "R8 frozen result and busy hold", result, r0);
            idle_in = 1'b0;
         end
      join
      cfg_freeze_idle = 1'b0;

      // R6: abort keeps queued words
      for (int k = 0; k < 8; k++) jw[k] = $urandom;
      push_words(8);
      cfg_go = 1'b1;
      repeat (12) @(negedge clk);
      cfg_go = 1'b0;
      @(negedge clk);
      chk(!busy, "R6 busy drops after abort", busy, 32'd0);
      r0 = result;
      repeat (5) @(negedge clk);
      chk(result == r0 && fifo_level == 7, "R6 result held and queue kept", {fifo_level, result[27:0]}, {4'd7, r0[27:0]});

      // R7: disable clears
      cfg_en = 1'b0;
      @(negedge clk);
      chk(fifo_level == 0 && fifo_empty && result == 0 && !busy, "R7 disable clears", {fifo_level, result[27:0]}, 32'd0);
      cfg_en = 1'b1;
      @(negedge clk);
      for (int k = 0; k < 2; k++) jw[k] = $urandom;
      push_words(2);
      run_job("after re-enable", 2, 1'b1);

      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

endmodule